// File: doc/BRIEF.md
# Serial Bus PHY Link-Side Register File

This block is the register file that a link controller uses to read and write a cable-environment serial bus PHY. A 4-bit register address selects one byte. A single-cycle write strobe carries address and data. A read strobe returns the addressed byte on the next clock edge. The lower half of the map holds several kinds of field: the node's self-identified address together with root and cable-power status; a root hold-off request; a self-clearing request to start a bus reset; the arbitration gap count; and fixed capability fields.

Writing the bus-reset request starts a fixed-length bus-reset pulse at once, with no arbitration first. The pulse length is set by a parameter equal to 166 microseconds times the clock frequency. When the node address equals the reserved value 63, the bus is misconfigured, and the block holds a transmit-inhibit output so that the link sends no packets.

Addresses 8 to 15 form a window onto eight bytes of simple storage. The page and port selected at address 7 decide which eight bytes the window shows.

Top module: `phy_regfile`

## Requirements
- R1: Address 0 reads {node_id_i[5:0], is_root_i, cable_pwr_i} in bits 7:2, 1 and 0, and writes to it have no effect.
- R2: tx_inhibit_o is 1 exactly when node_id_i equals 63, and 0 otherwise.
- R3: Bit 7 of address 1 is a read/write root hold-off bit, 0 after reset, and it drives root_holdoff_o.
- R4: Writing address 1 with bit 6 set starts a bus reset. Bit 6 always reads back as 0.
- R5: bus_reset_o rises in the cycle after the starting write and stays high for exactly RESET_CYCLES cycles. Another start while it is high restarts the full count.
- R6: Bits 5:0 of address 1 hold the read/write gap count. It resets to 0x3F and drives gap_count_o.
- R7: Address 2 reads {3'b111, NUM_PORTS[4:0]}. Address 3 reads {3'b010, 5'b0}. Writes to both have no effect.
- R8: Address 7 holds the page select in bits 7:5 and the port select in bits 3:0, both 0 after reset. Bit 4 reads 0.
- R9: Addresses 8 to 15 read and write byte offsets 0 to 7 of the storage for the selected page and port. Each storage byte is 0 after reset. When the port select is NUM_PORTS or more, or the page select is NUM_PAGES or more, the window reads 0 and ignores writes.
- R10: Addresses 4, 5 and 6 read 0 and ignore writes.
- R11: rdata_o changes only on an edge where rd_en_i is high, and is 0 after reset. A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id_i | input | 6 | Node address from self-identification |
| is_root_i | input | 1 | Node is root |
| cable_pwr_i | input | 1 | Cable power present |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid after the read edge |
| root_holdoff_o | output | 1 | Request to become root |
| gap_count_o | output | 6 | Arbitration gap count |
| bus_reset_o | output | 1 | Timed bus-reset pulse |
| tx_inhibit_o | output | 1 | Link transmit inhibit |

## Verification
Read data, the hold-off and gap-count outputs, and the bus-reset pulse all change one edge after the strobe that causes them. The transmit inhibit follows the node address within the same cycle. A behavioural model in the bench takes the same input values at each rising edge, updates its own state, and predicts every output. Each prediction is compared a quarter period after that edge, so a comparison never falls on the edge itself. Because the pulse is counted in the model with a plain integer, its first and last cycles and the restart are each checked on the exact cycle they are due.

// File: rtl/phy_regfile_pkg.sv
package phy_regfile_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NID_W    = 6;
  localparam int GAP_W    = 6;
  localparam int PAGE_W   = 3;
  localparam int PORT_W   = 4;
  localparam int WIN_REGS = 8;

  localparam logic [ADDR_W-1:0] A_STATUS = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CAPS   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SPEED  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SEL    = 4'd7;

  localparam logic [2:0] EXT_CODE   = 3'd7;
  localparam logic [2:0] SPEED_CODE = 3'b010;
  localparam logic [GAP_W-1:0] GAP_RST = 6'h3F;
endpackage

// File: rtl/phy_rst_timer.sv
module phy_rst_timer #(
  parameter int CYCLES = 8300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R5
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R5
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && cnt_q == CNT_W'(1)) |=> !busy_o);
endmodule

// File: rtl/phy_page_store.sv
module phy_page_store
  import phy_regfile_pkg::*;
#(
  parameter int NUM_PAGES = 8,
  parameter int NUM_PORTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [2:0]        offs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = NUM_PAGES * NUM_PORTS * WIN_REGS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  we;
  logic              hit;
  int                idx;
  logic [IDX_W-1:0]  idx_sel;

  always_comb begin
    hit     = (int'(page_i) < NUM_PAGES) && (int'(port_i) < NUM_PORTS);
    idx     = (int'(page_i) * NUM_PORTS + int'(port_i)) * WIN_REGS + int'(offs_i);
    idx_sel = hit ? IDX_W'(idx) : '0;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_we
    assign we[e] = wr_en_i && hit && (idx == e);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        if (we[e]) mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = hit ? mem_q[idx_sel] : '0;

  // R9
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_regfile_pkg::*;
#(
  parameter int RESET_CYCLES = 8300,
  parameter int NUM_PORTS    = 3,
  parameter int NUM_PAGES    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  node_id_i,
  input  logic        is_root_i,
  input  logic        cable_pwr_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [3:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        root_holdoff_o,
  output logic [5:0]  gap_count_o,
  output logic        bus_reset_o,
  output logic        tx_inhibit_o
);
  logic              rhb_q, rhb_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux, win_rdata;
  logic              wr_ctl, wr_sel, wr_win, rst_start;

  assign wr_ctl    = wr_en_i && (addr_i == A_CTRL);
  assign wr_sel    = wr_en_i && (addr_i == A_SEL);
  assign wr_win    = wr_en_i && addr_i[3];
  assign rst_start = wr_ctl && wdata_i[6];

  phy_page_store #(.NUM_PAGES(NUM_PAGES), .NUM_PORTS(NUM_PORTS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(wr_win),
    .page_i (page_q),
    .port_i (port_q),
    .offs_i (addr_i[2:0]),
    .wdata_i(wdata_i),
    .rdata_o(win_rdata)
  );

  phy_rst_timer #(.CYCLES(RESET_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(rst_start),
    .busy_o (bus_reset_o)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_STATUS: rd_mux = {node_id_i, is_root_i, cable_pwr_i};
      A_CTRL:   rd_mux = {rhb_q, 1'b0, gap_q};
      A_CAPS:   rd_mux = {EXT_CODE, 5'(NUM_PORTS)};
      A_SPEED:  rd_mux = {SPEED_CODE, 5'b0};
      A_SEL:    rd_mux = {page_q, 1'b0, port_q};
      default:  rd_mux = addr_i[3] ? win_rdata : '0;
    endcase
  end

  always_comb begin
    rhb_d   = rhb_q;
    gap_d   = gap_q;
    page_d  = page_q;
    port_d  = port_q;
    rdata_d = rdata_q;
    if (wr_ctl) begin
      rhb_d = wdata_i[7];
      gap_d = wdata_i[5:0];
    end
    if (wr_sel) begin
      page_d = wdata_i[7:5];
      port_d = wdata_i[3:0];
    end
    if (rd_en_i) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhb_q   <= 1'b0;
      gap_q   <= GAP_RST;
      page_q  <= '0;
      port_q  <= '0;
      rdata_q <= '0;
    end else begin
      rhb_q   <= rhb_d;
      gap_q   <= gap_d;
      page_q  <= page_d;
      port_q  <= port_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o        = rdata_q;
  assign root_holdoff_o = rhb_q;
  assign gap_count_o    = gap_q;
  assign tx_inhibit_o   = (node_id_i == 6'd63);

  // R3
  rhb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == A_CTRL) |=> $stable(root_holdoff_o));
  // R6
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == A_CTRL) |=> $stable(gap_count_o));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
  // R4
  ibr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_CTRL) |=> !rdata_o[6]);
endmodule

// File: tb/test_phy_regfile.sv
module test_phy_regfile;
  localparam int RST_CYC = 40;
  localparam int NPORTS  = 3;
  localparam int NPAGES  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] node_id = 6'd0;
  logic       is_root = 1'b0, cable_pwr = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       rhb_o, bus_rst, tx_inh;
  logic [5:0] gap_o;

  int errors = 0, checks = 0;
  bit done = 0;

  phy_regfile #(.RESET_CYCLES(RST_CYC), .NUM_PORTS(NPORTS), .NUM_PAGES(NPAGES)) i_phy_regfile (
    .clk(clk), .rst_n(rst_n), .node_id_i(node_id), .is_root_i(is_root),
    .cable_pwr_i(cable_pwr), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .root_holdoff_o(rhb_o),
    .gap_count_o(gap_o), .bus_reset_o(bus_rst), .tx_inhibit_o(tx_inh)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int    m_gap, m_rhb, m_cnt, m_page, m_port, m_rdata;
  int    m_mem [NPAGES][NPORTS][8];
  string m_tag = "R11";

  function automatic int model_read(int a);
    case (a)
      0: return (int'(node_id) << 2) | (int'(is_root) << 1) | int'(cable_pwr);
      1: return (m_rhb << 7) | m_gap;
      2: return (7 << 5) | NPORTS;
      3: return 2 << 5;
      7: return (m_page << 5) | m_port;
      default:
        if (a >= 8 && m_port < NPORTS && m_page < NPAGES) return m_mem[m_page][m_port][a-8];
        else return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R1";
      1: return "R4 R3 R6";
      2, 3: return "R7";
      4, 5, 6: return "R10";
      7: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gap = 63; m_rhb = 0; m_cnt = 0; m_page = 0; m_port = 0; m_rdata = 0;
      m_tag = "R11";
      foreach (m_mem[p, q, r]) m_mem[p][q][r] = 0;
    end else begin
      int a;
      a = int'(addr);
      if (rd_en) begin
        m_rdata = model_read(a);
        m_tag = tag_of(a);
      end else m_tag = "R11";
      if (wr_en && a == 1 && wdata[6]) m_cnt = RST_CYC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr_en) begin
        if (a == 1) begin m_rhb = int'(wdata[7]); m_gap = int'(wdata[5:0]); end
        if (a == 7) begin m_page = int'(wdata[7:5]); m_port = int'(wdata[3:0]); end
        if (a >= 8 && m_port < NPORTS && m_page < NPAGES) m_mem[m_page][m_port][a-8] = int'(wdata);
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, a quarter period after the rising edge
  always @(posedge clk) begin
    #5;
    check(m_tag, "rdata", int'(rdata), m_rdata);
    check("R3", "root_holdoff", int'(rhb_o), m_rhb);
    check("R6", "gap_count", int'(gap_o), m_gap);
    check("R5", "bus_reset", int'(bus_rst), (m_cnt > 0) ? 1 : 0);
    check("R2", "tx_inhibit", int'(tx_inh), (node_id == 6'd63) ? 1 : 0);
  end

  task automatic acc(bit w, bit r, int a, int d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state of every address (R11 reset rdata, R9 zero storage)
    for (int a = 0; a < 16; a++) acc(0, 1, a, 0);
    // R1: status fields and read-only behaviour
    node_id = 6'd5; is_root = 1; cable_pwr = 0;
    acc(0, 1, 0, 0);
    acc(1, 0, 0, 8'hFF);
    acc(0, 1, 0, 0);
    node_id = 6'd42; is_root = 0; cable_pwr = 1;
    acc(0, 1, 0, 0);
    // R2: reserved node address and its neighbour
    @(negedge clk); node_id = 6'd63; acc(0, 1, 0, 0);
    @(negedge clk); node_id = 6'd62; @(negedge clk);
    // R3 R6: control fields
    acc(1, 0, 1, 8'h95);
    acc(0, 1, 1, 0);
    acc(1, 0, 1, 8'h00);
    acc(0, 1, 1, 0);
    // R4 R5: bus reset, bit reads 0, restart while running
    acc(1, 0, 1, 8'hD5);
    acc(0, 1, 1, 0);
    repeat (15) @(negedge clk);
    acc(1, 0, 1, 8'h55);
    repeat (RST_CYC + 5) @(negedge clk);
    acc(1, 0, 1, 8'h40);
    repeat (RST_CYC + 3) @(negedge clk);
    // R7 R10: constant and reserved addresses ignore writes
    for (int a = 2; a < 7; a++) begin
      acc(1, 0, a, 8'hA5);
      acc(0, 1, a, 0);
    end
    // R8 R9: out-of-range port selects an empty window
    acc(1, 0, 7, 8'hFF);
    acc(0, 1, 7, 0);
    acc(1, 0, 9, 8'h77);
    acc(0, 1, 9, 0);
    acc(1, 0, 7, 8'h03);
    acc(0, 1, 12, 0);
    // R9: several pages and ports, write then read back
    for (int pg = 0; pg < 8; pg += 3) begin
      for (int pt = 0; pt < NPORTS; pt++) begin
        acc(1, 0, 7, (pg << 5) | pt);
        for (int o = 0; o < 8; o++) acc(1, 0, 8 + o, (pg * 37 + pt * 11 + o * 5 + 1) & 8'hFF);
      end
    end
    for (int pg = 0; pg < 8; pg += 3) begin
      for (int pt = 0; pt < NPORTS; pt++) begin
        acc(1, 1, 7, (pg << 5) | pt);
        for (int o = 0; o < 8; o++) acc(0, 1, 8 + o, 0);
      end
    end
    // R11: read and write together return old value, then new
    acc(1, 1, 13, 8'hC3);
    acc(0, 1, 13, 0);
    acc(1, 1, 1, 8'h2A);
    acc(0, 0, 0, 0);
    acc(0, 1, 1, 0);
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end
endmodule